// File: doc/BRIEF.md
# Variable-Page Access Protection Lookup

This block checks each core access address against a small associative table of protection entries. All entries are compared in parallel. Each entry pairs a base address word with a descriptor word. The descriptor holds a valid flag, a pinning flag, separate read/write/execute rights for user and supervisor mode, a cacheable attribute and a page size. The page size is 1 KiB, 4 KiB, 1 MiB or 4 MiB, and it sets how many high address bits take part in the compare. The result says whether the access hit an entry, missed every entry, or broke the rights of the entry it hit. The result also carries the cacheable attribute and the index of the winning entry.

The top 2 MiB of the address space holds the register region. The table never covers it. Accesses there are granted only to supervisor-mode reads and writes. A parameter picks the variant:
- The instruction-side variant judges fetches by execute rights.
- The data-side variant judges loads and stores by read or write rights.

Software fills the table through a plain indexed register write/read port. Refill and replacement are left to software: a miss is only reported.

Requests and results use valid/ready handshakes:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever the result register is empty, or is being drained in the same cycle (`res_ready` high).
- A result that has not been taken stays unchanged until `res_ready` is seen high.

Top module: `prot_lookup_top`

## Requirements
- R1: The page-size field is descriptor bits 17:16. Its values 0, 1, 2 and 3 select 1 KiB, 4 KiB, 1 MiB and 4 MiB pages. An entry matches when the address and the base agree on every bit above the page offset. Address bits inside the page offset are ignored.
- R2: Each entry has a 32-bit base word (`cfg_sel`=0) and a 32-bit descriptor word (`cfg_sel`=1). Both are written with `cfg_we` and read back combinationally on `cfg_rdata`. The descriptor keeps bits 0-7, 12 and 17:16. Every other descriptor bit reads back as 0.
- R3: An address at or above 0xFFE00000 never consults the table. Its result has hit=0, miss=0 and cacheable=0. It reports a violation in user mode, and on every instruction fetch.
- R4: Rights are held per mode:
  - User mode: bit 2 read, bit 3 write, bit 4 execute.
  - Supervisor mode: bit 5 read, bit 6 write, bit 7 execute.
  A hit whose needed right is clear reports violation=1. The needed right is execute for the instruction variant. For the data variant it is write when `req_write`=1 and read otherwise.
- R5: An address outside the register region that matches no valid entry (bit 0 = 1) reports miss=1, hit=0 and violation=0. Entries whose valid bit is clear are ignored.
- R6: When several valid entries match, the lowest index is reported and `res_multi` is 1. With exactly one match, `res_multi` is 0.
- R7: `res_cacheable` equals descriptor bit 12 of the winning entry on a hit, and is 0 otherwise.
- R8: The result appears with `res_valid`=1 in the cycle after acceptance. While `res_valid`=1 and `res_ready`=0, the result stays unchanged and `req_ready` is 0.
- R9: After reset every descriptor reads 0, no entry is valid, and `res_valid` is 0.
- R10: The lock bit (descriptor bit 1) is stored and read back but has no effect on matching, priority or rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table word write strobe |
| cfg_idx | input | 4 | Entry index for write and readback |
| cfg_sel | input | 1 | 0 selects the base word, 1 selects the descriptor |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Readback of the selected word |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this edge if valid |
| req_addr | input | 32 | Access address |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_write | input | 1 | Data variant: 1 = store, 0 = load |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | A valid entry matched |
| res_miss | output | 1 | No entry matched outside the register region |
| res_viol | output | 1 | Rights fault |
| res_cacheable | output | 1 | Cacheable attribute of the winner |
| res_multi | output | 1 | More than one entry matched |
| res_index | output | 4 | Index of the winning entry, 0 when none |

## Verification
The bench builds two copies with 16 entries. Both receive identical table writes and requests. One copy is the data variant (`IS_INSTR`=0) and the other is the instruction variant (`IS_INSTR`=1), so every request is judged against read/write rights and execute rights in the same run. Sixteen entries are enough to place pages of all four sizes side by side and to nest a 4 KiB page inside a 1 MiB page, which exercises priority. A 4 MiB entry reaches up to the register boundary and tests the bypass rule from both sides.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int WORD_W = 32;
  localparam logic [31:0] DESC_KEEP = 32'h0003_10FF;
  localparam int B_VALID = 0;
  localparam int B_LOCK  = 1;
  localparam int B_UR = 2, B_UW = 3, B_UX = 4;
  localparam int B_SR = 5, B_SW = 6, B_SX = 7;
  localparam int B_CACHE = 12;
  localparam int B_SZ_LO = 16;

  typedef enum logic [1:0] {
    PG_1K = 2'd0,
    PG_4K = 2'd1,
    PG_1M = 2'd2,
    PG_4M = 2'd3
  } page_sz_e;

  function automatic logic [31:0] cmp_mask(input page_sz_e sz);
    logic [31:0] m;
    unique case (sz)
      PG_1K:   m = ~32'h0000_03FF;
      PG_4K:   m = ~32'h0000_0FFF;
      PG_1M:   m = ~32'h000F_FFFF;
      default: m = ~32'h003F_FFFF;
    endcase
    return m;
  endfunction

  function automatic page_sz_e desc_size(input logic [31:0] d);
    return page_sz_e'(d[B_SZ_LO +: 2]);
  endfunction
endpackage

// File: rtl/prot_entry_store.sv
module prot_entry_store #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              sel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [31:0]       base_o [N_ENTRIES],
  output logic [31:0]       desc_o [N_ENTRIES]
);
  import prot_pkg::*;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic [31:0] base_q, desc_q;
    logic hit_sel;
    assign hit_sel = we && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        desc_q <= '0;
      end else if (hit_sel) begin
        if (sel) desc_q <= wdata & DESC_KEEP;
        else     base_q <= wdata;
      end
    end
    assign base_o[g] = base_q;
    assign desc_o[g] = desc_q;
  end

  always_comb begin
    rdata = sel ? desc_o[idx] : base_o[idx];
  end
endmodule

// File: rtl/prot_match_array.sv
module prot_match_array #(
  parameter int N_ENTRIES = 16
) (
  input  logic [31:0]          addr,
  input  logic [31:0]          base_i [N_ENTRIES],
  input  logic [31:0]          desc_i [N_ENTRIES],
  output logic [N_ENTRIES-1:0] match_o
);
  import prot_pkg::*;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic [31:0] mask;
    assign mask = cmp_mask(desc_size(desc_i[g]));
    assign match_o[g] = desc_i[g][B_VALID] && (((addr ^ base_i[g]) & mask) == '0);
  end
endmodule

// File: rtl/prot_hit_select.sv
module prot_hit_select #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] match_i,
  output logic                 any_o,
  output logic                 multi_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o   = |match_i;
  assign multi_o = $countones(match_i) > 1;
endmodule

// File: rtl/prot_lookup_top.sv
module prot_lookup_top #(
  parameter int          N_ENTRIES = 16,
  parameter bit          IS_INSTR  = 1'b0,
  parameter logic [31:0] REG_BASE  = 32'hFFE0_0000,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic             req_user,
  input  logic             req_write,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_hit,
  output logic             res_miss,
  output logic             res_viol,
  output logic             res_cacheable,
  output logic             res_multi,
  output logic [IDX_W-1:0] res_index
);
  import prot_pkg::*;

  logic [31:0]          base_w [N_ENTRIES];
  logic [31:0]          desc_w [N_ENTRIES];
  logic [N_ENTRIES-1:0] match_w;
  logic                 any_w, multi_w;
  logic [IDX_W-1:0]     idx_w;

  prot_entry_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .base_o(base_w), .desc_o(desc_w)
  );

  prot_match_array #(.N_ENTRIES(N_ENTRIES)) u_match (
    .addr(req_addr), .base_i(base_w), .desc_i(desc_w), .match_o(match_w)
  );

  prot_hit_select #(.N_ENTRIES(N_ENTRIES)) u_pick (
    .match_i(match_w), .any_o(any_w), .multi_o(multi_w), .idx_o(idx_w)
  );

  logic [31:0] win_desc;
  logic        in_regs, need_right, reg_fault;
  logic        n_hit, n_miss, n_viol, n_cache, n_multi;
  logic [IDX_W-1:0] n_idx;
  logic        unused_write;

  assign win_desc = desc_w[idx_w];
  assign in_regs  = req_addr >= REG_BASE;

  if (IS_INSTR) begin : g_fetch
    assign need_right   = req_user ? win_desc[B_UX] : win_desc[B_SX];
    assign reg_fault    = 1'b1;
    assign unused_write = req_write;
  end else begin : g_data
    always_comb begin
      unique case ({req_user, req_write})
        2'b00:   need_right = win_desc[B_SR];
        2'b01:   need_right = win_desc[B_SW];
        2'b10:   need_right = win_desc[B_UR];
        default: need_right = win_desc[B_UW];
      endcase
    end
    assign reg_fault    = req_user;
    assign unused_write = 1'b0;
  end

  always_comb begin
    n_hit   = 1'b0;
    n_miss  = 1'b0;
    n_viol  = 1'b0;
    n_cache = 1'b0;
    n_multi = 1'b0;
    n_idx   = '0;
    if (in_regs) begin
      n_viol = reg_fault;
    end else if (any_w) begin
      n_hit   = 1'b1;
      n_viol  = !need_right;
      n_cache = win_desc[B_CACHE];
      n_multi = multi_w;
      n_idx   = idx_w;
    end else begin
      n_miss = 1'b1;
    end
  end

  logic take;
  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_hit       <= 1'b0;
      res_miss      <= 1'b0;
      res_viol      <= 1'b0;
      res_cacheable <= 1'b0;
      res_multi     <= 1'b0;
      res_index     <= '0;
    end else if (take) begin
      res_valid     <= 1'b1;
      res_hit       <= n_hit;
      res_miss      <= n_miss;
      res_viol      <= n_viol;
      res_cacheable <= n_cache;
      res_multi     <= n_multi;
      res_index     <= n_idx;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable({res_hit, res_miss, res_viol,
      res_cacheable, res_multi, res_index}));
  // R8
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid);
  // R5
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_hit && res_miss));
  // R4
  viol_not_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_viol |-> !res_miss);
  // R6
  multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_multi |-> res_hit);
  // R7
  cache_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_cacheable |-> res_hit);
  // R6
  winner_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_w |-> match_w[idx_w]);
endmodule

// File: tb/prot_lookup_top_tb_top.sv
module prot_lookup_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 0, cfg_sel = 0;
  logic [3:0]  cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic        req_valid = 0, req_user = 0, req_write = 0, res_ready = 1;
  logic [31:0] req_addr = 0;

  logic [31:0] d_rdata, f_rdata;
  logic d_rdy, d_val, d_hit, d_miss, d_viol, d_cach, d_multi;
  logic f_rdy, f_val, f_hit, f_miss, f_viol, f_cach, f_multi;
  logic [3:0] d_idx, f_idx;

  prot_lookup_top #(.N_ENTRIES(16), .IS_INSTR(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(d_rdata), .req_valid(req_valid), .req_ready(d_rdy),
    .req_addr(req_addr), .req_user(req_user), .req_write(req_write), .res_valid(d_val),
    .res_ready(res_ready), .res_hit(d_hit), .res_miss(d_miss), .res_viol(d_viol),
    .res_cacheable(d_cach), .res_multi(d_multi), .res_index(d_idx));

  prot_lookup_top #(.N_ENTRIES(16), .IS_INSTR(1'b1)) dut_f (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(f_rdata), .req_valid(req_valid), .req_ready(f_rdy),
    .req_addr(req_addr), .req_user(req_user), .req_write(req_write), .res_valid(f_val),
    .res_ready(res_ready), .res_hit(f_hit), .res_miss(f_miss), .res_viol(f_viol),
    .res_cacheable(f_cach), .res_multi(f_multi), .res_index(f_idx));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic s, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(i); cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input logic [31:0] a, input logic u, input logic w);
    @(negedge clk);
    req_addr = a; req_user = u; req_write = w; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  // data-side outputs: {valid,hit,miss,viol,cache,multi,idx}
  function automatic logic [31:0] dres();
    return {22'd0, d_val, d_hit, d_miss, d_viol, d_cach, d_multi, d_idx};
  endfunction
  function automatic logic [31:0] pack(input logic h, m, v, c, mu, input logic [3:0] ix);
    return {22'd0, 1'b1, h, m, v, c, mu, ix};
  endfunction

  task automatic t_reset();
    chk("R9 res_valid after reset", d_val, 0);
    @(negedge clk); cfg_idx = 0; cfg_sel = 1; #1;
    chk("R9 descriptor 0 zero", d_rdata, 0);
    access(32'h0000_0000, 0, 0);
    chk("R9 R5 empty table miss", dres(), pack(0, 1, 0, 0, 0, 0));
  endtask

  task automatic t_small_pages();
    wr(0, 0, 32'h0000_0400); wr(0, 1, 32'h0000_10E5);
    access(32'h0000_07FC, 0, 0);
    chk("R1 R7 1K top hit", dres(), pack(1, 0, 0, 1, 0, 0));
    chk("R4 sup fetch allowed", f_viol, 0);
    access(32'h0000_0800, 0, 0);
    chk("R1 1K upper boundary miss", dres(), pack(0, 1, 0, 0, 0, 0));
    access(32'h0000_03FC, 0, 0);
    chk("R1 1K lower boundary miss", d_miss, 1);
    access(32'h0000_0400, 1, 1);
    chk("R4 user write denied", dres(), pack(1, 0, 1, 1, 0, 0));
    access(32'h0000_0400, 1, 0);
    chk("R4 user read allowed", d_viol, 0);
    chk("R4 user fetch denied", f_viol, 1);
  endtask

  task automatic t_priority();
    wr(1, 0, 32'h0010_0000); wr(1, 1, 32'h0002_006D);
    access(32'h001F_FFFF, 1, 1);
    chk("R1 1M hit", dres(), pack(1, 0, 0, 0, 0, 1));
    chk("R4 fetch without execute", f_viol, 1);
    access(32'h0020_0000, 0, 0);
    chk("R1 1M boundary miss", d_miss, 1);
    wr(3, 0, 32'h0010_3000); wr(3, 1, 32'h0001_10FF);
    access(32'h0010_3010, 0, 0);
    chk("R6 lowest index wins", dres(), pack(1, 0, 0, 0, 1, 1));
    wr(1, 1, 32'h0002_006C);
    access(32'h0010_3010, 0, 0);
    chk("R5 R6 invalid entry skipped", dres(), pack(1, 0, 0, 1, 0, 3));
    access(32'h0010_3FFF, 0, 0);
    chk("R1 4K top hit", d_idx, 3);
    access(32'h0010_4000, 0, 0);
    chk("R1 4K boundary miss", d_miss, 1);
    wr(3, 1, 32'h0001_10FD);
    access(32'h0010_3010, 0, 0);
    chk("R10 lock cleared same result", dres(), pack(1, 0, 0, 1, 0, 3));
  endtask

  task automatic t_big_page();
    wr(5, 0, 32'h0080_0000); wr(5, 1, 32'h0003_1011);
    access(32'h00BF_FFF0, 1, 0);
    chk("R4 4M user read denied", dres(), pack(1, 0, 1, 1, 0, 5));
    chk("R4 4M user fetch allowed", f_viol, 0);
    access(32'h00BF_FFF0, 0, 0);
    chk("R4 sup fetch denied", f_viol, 1);
    access(32'h00C0_0000, 0, 0);
    chk("R1 4M boundary miss", f_miss, 1);
  endtask

  task automatic t_readback();
    wr(7, 0, 32'h1234_5678); wr(7, 1, 32'hFFFF_FFFF);
    @(negedge clk); cfg_idx = 7; cfg_sel = 0; #1;
    chk("R2 base readback", d_rdata, 32'h1234_5678);
    cfg_sel = 1; #1;
    chk("R2 R10 descriptor readback masked", d_rdata, 32'h0003_10FF);
    chk("R2 fetch copy readback", f_rdata, 32'h0003_10FF);
  endtask

  task automatic t_reg_region();
    wr(8, 0, 32'hFFC0_0000); wr(8, 1, 32'h0003_10FF);
    access(32'hFFDF_FFFC, 1, 1);
    chk("R3 just below region uses table", dres(), pack(1, 0, 0, 1, 0, 8));
    access(32'hFFE0_0000, 0, 0);
    chk("R3 sup read region", dres(), pack(0, 0, 0, 0, 0, 0));
    chk("R3 fetch region faults", f_viol, 1);
    chk("R3 fetch region no miss", f_miss, 0);
    access(32'hFFFF_FFFC, 0, 1);
    chk("R3 sup write region", dres(), pack(0, 0, 0, 0, 0, 0));
    access(32'hFFE0_0010, 1, 0);
    chk("R3 user region faults", dres(), pack(0, 0, 1, 0, 0, 0));
  endtask

  task automatic t_backpressure();
    @(negedge clk); res_ready = 0;
    access(32'h0000_07FC, 0, 0);
    chk("R8 held result", dres(), pack(1, 0, 0, 1, 0, 0));
    req_addr = 32'h0000_0800; req_valid = 1;
    for (int k = 0; k < 3; k++) begin
      #0.5;
      chk("R8 ready low while full", d_rdy, 0);
      chk("R8 result stable", dres(), pack(1, 0, 0, 1, 0, 0));
      @(negedge clk);
    end
    res_ready = 1; #0.5;
    chk("R8 ready with drain", d_rdy, 1);
    @(negedge clk); req_valid = 0;
    chk("R8 next result after drain", dres(), pack(0, 1, 0, 0, 0, 0));
    @(negedge clk);
    chk("R8 valid drops when drained", d_val, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_small_pages();
    t_priority();
    t_big_page();
    t_readback();
    t_reg_region();
    t_backpressure();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule